// File: doc/BRIEF.md
# Handshake Output Strobe Controller

This block drives the outgoing strobe of a parallel port that runs a handshake with an external device. When a port access starts a transfer, the block raises the output strobe. It then waits for a reason to stop. In interlocked mode that reason is the programmed edge on the incoming strobe from the peripheral. In pulsed mode the strobe ends by itself after one bus (E) cycle. A third reason covers software that switches the port from interlocked to pulsed operation while a strobe is still up.

Every termination lands on the internal tick, and that tick always falls in the middle of the low half of E. The block makes its own E phase and tick from the system clock. CLK_PER_E system clocks make one E cycle. E is high for the first half and low for the second half, and the tick comes three quarters of the way through. An internal end-of-strobe flag records that a termination is pending, and the block also drives it out. The incoming strobe is asynchronous, so it passes through a two-stage synchroniser before edge detection.

Top module: `hs_strobe_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the strobe and end-of-strobe outputs go low and the E phase restarts, so `e_clk` reads high after every reset clock.
- R2: `e_clk` is high for the first CLK_PER_E/2 clocks after reset release and low for the next CLK_PER_E/2, then repeats. The tick is the clock at phase index 3·CLK_PER_E/4, which is in the low half.
- R3: With handshake enabled, a start pulse raises the strobe at the next clock edge and clears any pending end-of-strobe.
- R4: In interlocked mode (pulse bit 0), a selected edge on the input strobe while the strobe is high sets end-of-strobe at the third clock edge after the input changes.
- R5: The edge-select bit picks the active edge: 1 selects rising and 0 selects falling. The opposite edge has no effect.
- R6: The strobe and end-of-strobe fall together, and only at the edge that ends a tick clock with end-of-strobe pending, or when handshake is disabled. End-of-strobe is never high while the strobe is low.
- R7: A transfer started in pulsed mode (pulse bit 1) sets end-of-strobe one clock later. A start given in a tick clock gives a strobe exactly CLK_PER_E clocks long.
- R8: A configuration write with the pulse bit at 1 while the strobe is high sets end-of-strobe at the next clock. The strobe then ends at the following tick. Such a write while the strobe is low does nothing.
- R9: With handshake disabled, the strobe and end-of-strobe are low after the next clock, and start pulses are ignored.
- R10: A start pulse in the same clock as a pending tick termination wins: the strobe stays high and end-of-strobe clears.
- R11: Input-strobe edges that occur while the strobe is low are not remembered, and do not shorten a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_en | input | 1 | Handshake enable |
| pulse_mode | input | 1 | 1 = pulsed, 0 = interlocked |
| edge_rise | input | 1 | Active input edge: 1 rising, 0 falling |
| cfg_wr | input | 1 | One-clock write strobe of the control bits |
| xfer_start | input | 1 | One-clock start of a port transfer |
| strb_in | input | 1 | Asynchronous strobe from the peripheral |
| e_clk | output | 1 | Generated E phase |
| strb_out | output | 1 | Output strobe, active high |
| eos | output | 1 | End-of-strobe pending |

## Verification
The hardest cases to reach from the ports are two collisions. One is a start pulse that arrives in the very tick clock that would otherwise end a strobe. The other is a mode switch written while an interlocked strobe is waiting for an edge. The bench reaches both by counting clocks from reset release, because the E phase then follows a known pattern. It places starts, control writes and input edges on chosen phase indices. It also allows for the two synchroniser clocks plus the edge-detect clock when it times each input change.

// File: rtl/hs_pkg.sv
// Shared types for the handshake strobe controller.
package hs_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic      hs_en;
        logic      pulse_mode;
        edge_pol_e edge_pol;
    } hs_cfg_t;

    // True when the pair (current, previous) forms the selected transition.
    function automatic logic edge_hit(edge_pol_e pol, logic cur, logic prev);
        return (pol == EDGE_RISE) ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/hs_phase_gen.sv
// E phase generator: divides the system clock into E cycles of CLK_PER_E
// clocks, E high for the first half, and emits a one-clock tick at the
// centre of the low half. Assumes CLK_PER_E is a multiple of 4.
module hs_phase_gen #(
    parameter int CLK_PER_E = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic e_clk,
    output logic tick
);
    localparam int CW      = (CLK_PER_E > 2) ? $clog2(CLK_PER_E) : 1;
    localparam int HALF    = CLK_PER_E / 2;
    localparam int TICK_AT = HALF + HALF / 2;
    localparam logic [CW-1:0] LAST    = CW'(CLK_PER_E - 1);
    localparam logic [CW-1:0] HALF_V  = CW'(HALF);
    localparam logic [CW-1:0] TICK_V  = CW'(TICK_AT);

    logic [CW-1:0] cnt;

    // Phase counter, wraps once per E cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign e_clk = (cnt < HALF_V);
    assign tick  = (cnt == TICK_V);

    // The tick must lie in the E-low half.
    assert_tick_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !e_clk);

    // E falls only at the middle of the cycle, never straight after a tick.
    assert_fall_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !$fell(e_clk));

endmodule

// File: rtl/hs_edge_sync.sv
// Input strobe synchroniser and edge detector. STAGES flops bring the
// asynchronous pin into the clock domain; one more flop holds the previous
// synchronised value for the comparison. Assumes STAGES >= 2.
module hs_edge_sync
    import hs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din,
    input  edge_pol_e pol,
    output logic      edge_det
);
    logic [STAGES:0] sh;

    // Shift the pin through the synchroniser and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign edge_det = edge_hit(pol, sh[STAGES-1], sh[STAGES]);

endmodule

// File: rtl/hs_strobe_core.sv
// Output strobe state and end-of-strobe collection. A start raises the
// strobe; one of three sources (interlocked edge, pulsed auto-end, mode
// switch write) sets end-of-strobe; the strobe drops on the next tick.
// Assumes start, cfg_wr and tick are single-clock pulses.
module hs_strobe_core
    import hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  hs_cfg_t cfg,
    input  logic    cfg_wr,
    input  logic    start,
    input  logic    edge_det,
    input  logic    tick,
    output logic    strb,
    output logic    eos
);
    logic pulsed_xfer;
    logic src_lock, src_pulse, src_switch, end_req, ending;

    // The three end-of-strobe sources.
    assign src_lock   = ~cfg.pulse_mode & edge_det;
    assign src_pulse  = pulsed_xfer;
    assign src_switch = cfg_wr & cfg.pulse_mode;
    assign end_req    = src_lock | src_pulse | src_switch;
    assign ending     = tick & eos;

    // Strobe, end-of-strobe and latched transfer mode, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb        <= 1'b0;
            eos         <= 1'b0;
            pulsed_xfer <= 1'b0;
        end else if (!cfg.hs_en) begin
            strb        <= 1'b0;
            eos         <= 1'b0;
            pulsed_xfer <= 1'b0;
        end else if (start) begin
            strb        <= 1'b1;
            eos         <= 1'b0;
            pulsed_xfer <= cfg.pulse_mode;
        end else if (ending) begin
            strb        <= 1'b0;
            eos         <= 1'b0;
        end else if (strb && end_req) begin
            eos         <= 1'b1;
        end
    end

    assert_start_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_en && start) |=> (strb && !eos));

    assert_edge_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_en && !start && strb && !ending && !cfg.pulse_mode && edge_det) |=> eos);

    assert_eos_with_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> strb);

    assert_hold_off_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_en && strb && !tick) |=> strb);

    assert_switch_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_en && !start && strb && !ending && cfg_wr && cfg.pulse_mode) |=> eos);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.hs_en |=> (!strb && !eos));

    assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_en && start && ending) |=> strb);

endmodule

// File: rtl/hs_strobe_ctrl.sv
// Top of the handshake output strobe controller: E phase generator, input
// strobe synchroniser and the strobe core. All control bits are taken as
// level inputs; cfg_wr marks the clock in which they were written.
module hs_strobe_ctrl
    import hs_pkg::*;
#(
    parameter int CLK_PER_E   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic pulse_mode,
    input  logic edge_rise,
    input  logic cfg_wr,
    input  logic xfer_start,
    input  logic strb_in,
    output logic e_clk,
    output logic strb_out,
    output logic eos
);
    hs_cfg_t cfg;
    logic    tick;
    logic    edge_det;

    assign cfg.hs_en      = hs_en;
    assign cfg.pulse_mode = pulse_mode;
    assign cfg.edge_pol   = edge_pol_e'(edge_rise);

    hs_phase_gen #(.CLK_PER_E(CLK_PER_E)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .e_clk (e_clk),
        .tick  (tick)
    );

    hs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (strb_in),
        .pol      (cfg.edge_pol),
        .edge_det (edge_det)
    );

    hs_strobe_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .cfg_wr   (cfg_wr),
        .start    (xfer_start),
        .edge_det (edge_det),
        .tick     (tick),
        .strb     (strb_out),
        .eos      (eos)
    );

endmodule

// File: tb/sim_hs_strobe_ctrl.sv
// Bench: vector table walked cycle by cycle from reset release (E phase
// index = vector index mod 4, tick at index 3), then directed tests.
module sim_hs_strobe_ctrl;
    localparam int CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_en = 1'b1, pulse_mode = 1'b0, edge_rise = 1'b0;
    logic cfg_wr = 1'b0, xfer_start = 1'b0, strb_in = 1'b1;
    logic e_clk, strb_out, eos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    hs_strobe_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .pulse_mode(pulse_mode),
        .edge_rise(edge_rise), .cfg_wr(cfg_wr), .xfer_start(xfer_start),
        .strb_in(strb_in), .e_clk(e_clk), .strb_out(strb_out), .eos(eos)
    );

    // {req, inputs en pl er cw st si, expected strb eos e}
    localparam int NV = 60;
    localparam logic [12:0] VEC [NV] = '{
        {4'd2, 6'b100001, 3'b001},  // R2 idle phase
        {4'd2, 6'b100001, 3'b000},
        {4'd2, 6'b100001, 3'b000},
        {4'd3, 6'b100011, 3'b101},  // R3 start in tick
        {4'd3, 6'b100001, 3'b101},
        {4'd4, 6'b100000, 3'b100},  // R4 falling edge on input
        {4'd4, 6'b100000, 3'b100},
        {4'd4, 6'b100000, 3'b111},  // R4 eos third edge after change
        {4'd6, 6'b100000, 3'b111},  // R6 held to tick
        {4'd6, 6'b100000, 3'b110},
        {4'd6, 6'b100000, 3'b110},
        {4'd6, 6'b100000, 3'b001},  // R6 drop at tick
        {4'd2, 6'b100000, 3'b001},
        {4'd2, 6'b100000, 3'b000},
        {4'd2, 6'b100000, 3'b000},
        {4'd3, 6'b100010, 3'b101},
        {4'd5, 6'b100001, 3'b101},  // R5 rising edge, falling selected
        {4'd5, 6'b100001, 3'b100},
        {4'd5, 6'b100001, 3'b100},
        {4'd5, 6'b100001, 3'b101},
        {4'd5, 6'b100001, 3'b101},
        {4'd5, 6'b100001, 3'b100},
        {4'd5, 6'b100001, 3'b100},
        {4'd5, 6'b100001, 3'b101},
        {4'd5, 6'b101000, 3'b101},  // R5 select rising, falling input ignored
        {4'd5, 6'b101000, 3'b100},
        {4'd5, 6'b101001, 3'b100},
        {4'd5, 6'b101001, 3'b101},
        {4'd5, 6'b101001, 3'b111},  // R5 rising edge arms eos
        {4'd6, 6'b101001, 3'b110},
        {4'd6, 6'b101001, 3'b110},
        {4'd6, 6'b101001, 3'b001},
        {4'd2, 6'b101001, 3'b001},
        {4'd2, 6'b101001, 3'b000},
        {4'd2, 6'b101001, 3'b000},
        {4'd3, 6'b101011, 3'b101},  // interlocked start
        {4'd8, 6'b101001, 3'b101},
        {4'd8, 6'b111101, 3'b110},  // R8 write pulse bit mid-strobe
        {4'd8, 6'b111001, 3'b110},
        {4'd8, 6'b111001, 3'b001},  // R8 ends at tick
        {4'd2, 6'b111001, 3'b001},
        {4'd2, 6'b111001, 3'b000},
        {4'd2, 6'b111001, 3'b000},
        {4'd7, 6'b111011, 3'b101},  // R7 pulsed start in tick
        {4'd7, 6'b111001, 3'b111},
        {4'd7, 6'b111001, 3'b110},
        {4'd7, 6'b111001, 3'b110},
        {4'd7, 6'b111001, 3'b001},  // R7 four clocks long
        {4'd2, 6'b111001, 3'b001},
        {4'd2, 6'b111001, 3'b000},
        {4'd2, 6'b111001, 3'b000},
        {4'd7, 6'b111011, 3'b101},
        {4'd7, 6'b111001, 3'b111},
        {4'd7, 6'b111001, 3'b110},
        {4'd7, 6'b111001, 3'b110},
        {4'd10, 6'b111011, 3'b101}, // R10 start at terminating tick
        {4'd10, 6'b111001, 3'b111},
        {4'd7, 6'b111001, 3'b110},
        {4'd7, 6'b111001, 3'b110},
        {4'd7, 6'b111001, 3'b001}
    };

    task automatic chk(input string what, input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_out(input string tag, input logic es, input logic ee, input logic ec);
        chk("strb_out", tag, strb_out, es);
        chk("eos", tag, eos, ee);
        chk("e_clk", tag, e_clk, ec);
    endtask

    // Drive at the falling edge, sample 2 ns after the rising edge, return to falling edge.
    task automatic step(input logic [5:0] in, input logic [2:0] exp, input string tag);
        {hs_en, pulse_mode, edge_rise, cfg_wr, xfer_start, strb_in} = in;
        @(posedge clk);
        #2;
        check_out(tag, exp[2], exp[1], exp[0]);
        @(negedge clk);
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_out("R1", 1'b0, 1'b0, 1'b1);  // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8:3], VEC[i][2:0], $sformatf("R%0d", VEC[i][12:9]));
        end
        // R9: disable mid-strobe, starts ignored while disabled
        step(6'b101011, 3'b101, "R9");
        step(6'b001001, 3'b000, "R9");
        step(6'b001011, 3'b000, "R9");
        step(6'b011101, 3'b001, "R9");
        // R8: pulse-bit write with strobe low leaves eos low
        step(6'b111101, 3'b001, "R8");
        // R11: rising edge while idle is forgotten
        step(6'b101000, 3'b000, "R11");
        step(6'b101000, 3'b000, "R11");
        step(6'b101001, 3'b001, "R11");
        step(6'b101001, 3'b001, "R11");
        step(6'b101001, 3'b000, "R11");
        step(6'b101001, 3'b000, "R11");
        step(6'b101011, 3'b101, "R11");
        step(6'b101001, 3'b101, "R11");
        step(6'b101001, 3'b100, "R11");
        step(6'b101001, 3'b100, "R11");
        step(6'b101001, 3'b101, "R11");
        step(6'b001001, 3'b001, "R9");
        // R1: reset in the middle of a strobe
        step(6'b101011, 3'b100, "R3");
        rst_n = 1'b0;
        step(6'b101001, 3'b001, "R1");
        step(6'b101001, 3'b001, "R1");
        rst_n = 1'b1;
        step(6'b101001, 3'b001, "R2");
        step(6'b101001, 3'b000, "R2");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule